// File: doc/BRIEF.md
# Microsecond Time-of-Day Counter

This block keeps a free-running timestamp split into three decimal-aware fields: a 4-bit count of tenths of a microsecond, a 20-bit microsecond count and a 32-bit seconds count. A prescaler turns the system clock into one 100 ns tick. Each tick advances the tenths field. When the tenths field wraps, the carry moves into the microseconds field. When the microseconds field wraps, the carry moves into the seconds field.

Software reaches the counter through a 16-bit word port with a 2-bit word select. A new time is written as four words. The first three words are held in staging registers, and the write of the top word loads the whole value at once and starts the counter. Reading the low word captures a copy of all fields in the same cycle. Later reads of the other three words return that copy, so a multi-word read always describes one instant. An `armed` output shows that the counter has been loaded and is counting.

Top module: `usec_tod_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes all zero, `armed` goes low and `rd_data` goes to 0.
- R2: While `armed` is low, the count does not change and reads return 0.
- R3: Writes to word 0, 1 or 2 only update staging registers. They change neither the count nor `armed`.
- R4: A write to word 3 loads the count in that cycle from the staged words 0 to 2 and `wr_data`, and sets `armed`. Only reset clears `armed`. The write also restarts the prescaler, so the first advance comes `TICK_DIV` cycles after the load.
- R5: While armed, the tenths field advances once every `TICK_DIV` clock cycles and wraps from 9 to 0, with a carry into microseconds.
- R6: Microseconds count from 0 to 999999. On a carry from 999999 the field wraps to 0 and the seconds field increments.
- R7: Seconds is a 32-bit field that wraps from 0xFFFFFFFF to 0.
- R8: Word layout: word 0 is microseconds[15:0]. Word 1 has microseconds[19:16] in bits 3:0, tenths in bits 7:4 and zero in bits 15:8. Word 2 is seconds[15:0]. Word 3 is seconds[31:16]. Loads use the same layout.
- R9: `rd_data` is registered and updates one cycle after `rd_en`, otherwise it holds its value. A read of word 0 returns the live count and captures a copy of all fields. Reads of words 1 to 3 return the captured copy.
- R10: On a load, a tenths value above 9 becomes 9 and a microseconds value above 999999 becomes 999999.
- R11: When a load and a prescaler tick fall in the same cycle, the loaded value is kept and no advance is applied to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| rd_en | input | 1 | Read strobe for the selected word |
| word_sel | input | 2 | Word select for reads and writes |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| armed | output | 1 | High once loaded and counting |

## Verification
A bad carry or a bad wrap limit shows up at the latest one tick after the faulty state. It appears as a wrong low or high word on the next read, and the low-word read shows the live count with one cycle of latency. A bad snapshot stays hidden until one tick passes between the low-word read and a later word read. For that reason the bench spaces some reads several ticks apart. Prescaler faults show as reads that land one cycle before and one cycle after the expected tick edge and disagree with the model. The bench also places a load on a tick edge, where a wrong priority between the two changes the tenths field.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_WORDS = 4;
    localparam int SEL_W     = $clog2(NUM_WORDS);
    localparam int TENTH_W   = 4;
    localparam int USEC_W    = 20;
    localparam int SEC_W     = 32;
    localparam int USEC_LO_W = WORD_W;
    localparam int USEC_HI_W = USEC_W - USEC_LO_W;

    localparam logic [TENTH_W-1:0] TENTH_LAST = TENTH_W'(9);
    localparam logic [USEC_W-1:0]  USEC_LAST  = USEC_W'(999999);

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [SEC_W-1:0]   sec;
        logic [USEC_W-1:0]  usec;
        logic [TENTH_W-1:0] tenth;
    } tod_t;

    typedef enum logic [SEL_W-1:0] {
        WORD_USEC_LO = 2'd0,
        WORD_FRAC    = 2'd1,
        WORD_SEC_LO  = 2'd2,
        WORD_SEC_HI  = 2'd3
    } word_e;

    function automatic word_t tod_word(input tod_t t, input word_e sel);
        word_t w;
        case (sel)
            WORD_USEC_LO: w = t.usec[USEC_LO_W-1:0];
            WORD_FRAC:    w = {{(WORD_W-TENTH_W-USEC_HI_W){1'b0}}, t.tenth,
                               t.usec[USEC_W-1:USEC_LO_W]};
            WORD_SEC_LO:  w = t.sec[WORD_W-1:0];
            default:      w = t.sec[SEC_W-1:WORD_W];
        endcase
        return w;
    endfunction

    function automatic tod_t tod_unpack(input word_t w0, input word_t w1,
                                        input word_t w2, input word_t w3);
        tod_t                t;
        logic [TENTH_W-1:0]  raw_tenth;
        logic [USEC_W-1:0]   raw_usec;
        raw_tenth = w1[USEC_HI_W +: TENTH_W];
        raw_usec  = {w1[USEC_HI_W-1:0], w0};
        t.tenth   = (raw_tenth > TENTH_LAST) ? TENTH_LAST : raw_tenth;
        t.usec    = (raw_usec > USEC_LAST) ? USEC_LAST : raw_usec;
        t.sec     = {w3, w2};
        return t;
    endfunction

    function automatic tod_t tod_step(input tod_t t);
        tod_t n;
        n = t;
        if (t.tenth >= TENTH_LAST) begin
            n.tenth = '0;
            if (t.usec >= USEC_LAST) begin
                n.usec = '0;
                n.sec  = t.sec + SEC_W'(1);
            end else begin
                n.usec = t.usec + USEC_W'(1);
            end
        end else begin
            n.tenth = t.tenth + TENTH_W'(1);
        end
        return n;
    endfunction

endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
    parameter int TICK_DIV = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICK_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == CNT_LAST) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    assign tick = run && (cnt_q == CNT_LAST);

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  tod_t load_val,
    input  logic tick,
    output tod_t value,
    output logic armed
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            armed <= 1'b0;
        end else if (load) begin
            value <= load_val;
            armed <= 1'b1;
        end else if (armed && tick) begin
            value <= tod_step(value);
        end
    end

endmodule

// File: rtl/tod_access.sv
module tod_access
    import tod_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  word_sel,
    input  word_t             wr_data,
    input  tod_t              live,
    output logic              commit,
    output tod_t              commit_val,
    output word_t             rd_data
);
    localparam int STAGE_N = NUM_WORDS - 1;

    word_t stage_q [STAGE_N];
    tod_t  snap_q;
    tod_t  rd_src;
    word_e sel_e;

    assign sel_e = word_e'(word_sel);

    generate
        for (genvar g = 0; g < STAGE_N; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stage_q[g] <= '0;
                end else if (wr_en && (word_sel == SEL_W'(g))) begin
                    stage_q[g] <= wr_data;
                end
            end
        end
    endgenerate

    assign commit     = wr_en && (sel_e == WORD_SEC_HI);
    assign commit_val = tod_unpack(stage_q[0], stage_q[1], stage_q[2], wr_data);

    assign rd_src = (sel_e == WORD_USEC_LO) ? live : snap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q  <= '0;
            rd_data <= '0;
        end else if (rd_en) begin
            if (sel_e == WORD_USEC_LO) begin
                snap_q <= live;
            end
            rd_data <= tod_word(rd_src, sel_e);
        end
    end

endmodule

// File: rtl/usec_tod_timer.sv
module usec_tod_timer
    import tod_pkg::*;
#(
    parameter int TICK_DIV = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [1:0]  word_sel,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        armed
);
    tod_t live;
    tod_t load_val;
    logic commit;
    logic tick;

    tod_prescaler #(.TICK_DIV(TICK_DIV)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .run     (armed),
        .restart (commit),
        .tick    (tick)
    );

    tod_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .load     (commit),
        .load_val (load_val),
        .tick     (tick),
        .value    (live),
        .armed    (armed)
    );

    tod_access u_access (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .word_sel   (word_sel),
        .wr_data    (wr_data),
        .live       (live),
        .commit     (commit),
        .commit_val (load_val),
        .rd_data    (rd_data)
    );

endmodule

// File: rtl/tod_checker.sv
module tod_checker #(
    parameter int TICK_DIV = 20
) (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  word_sel,
    input logic        armed,
    input logic        tick,
    input logic [3:0]  tenth,
    input logic [19:0] usec,
    input logic [31:0] sec
);
    logic load_now;
    logic step_now;
    assign load_now = wr_en && (word_sel == 2'd3);
    assign step_now = armed && tick && !load_now;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!armed && tenth == 4'd0 && usec == 20'd0 && sec == 32'd0)); // R1

    AST_HOLD_DISARMED: assert property (@(posedge clk) disable iff (rst)
        (!armed && !load_now) |=> ($stable(tenth) && $stable(usec) && $stable(sec))); // R2

    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        load_now |=> armed); // R4

    AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed); // R4

    AST_TENTH_RANGE: assert property (@(posedge clk) disable iff (rst)
        tenth <= 4'd9); // R5

    AST_TENTH_STEP: assert property (@(posedge clk) disable iff (rst)
        (step_now && tenth < 4'd9) |=> (tenth == $past(tenth) + 4'd1)); // R5

    AST_TENTH_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_now && tenth == 4'd9) |=> (tenth == 4'd0)); // R5

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && (TICK_DIV > 1)) |=> !tick); // R5

    AST_USEC_RANGE: assert property (@(posedge clk) disable iff (rst)
        usec <= 20'd999999); // R6

    AST_USEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_now && tenth == 4'd9 && usec == 20'd999999)
        |=> (usec == 20'd0 && sec == $past(sec) + 32'd1)); // R6

    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (rst)
        (step_now && tenth == 4'd9 && usec == 20'd999999 && sec == 32'hFFFF_FFFF)
        |=> (sec == 32'd0)); // R7

endmodule

bind usec_tod_timer tod_checker #(.TICK_DIV(TICK_DIV)) u_tod_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .word_sel (word_sel),
    .armed    (armed),
    .tick     (tick),
    .tenth    (live.tenth),
    .usec     (live.usec),
    .sec      (live.sec)
);

// File: tb/usec_tod_timer_tb_top.sv
`timescale 1ns/1ps
module usec_tod_timer_tb_top;
    localparam int DIV = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  word_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic [15:0] rd_data;
    logic        armed;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit seen_edge = 1'b0;

    always #2.5 clk = ~clk;

    usec_tod_timer #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
        .word_sel(word_sel), .wr_data(wr_data), .rd_data(rd_data), .armed(armed)
    );

    // behavioural reference
    int          m_tenth = 0, m_usec = 0, m_presc = 0;
    longint      m_sec = 0;
    bit          m_armed = 1'b0;
    int          s_tenth = 0, s_usec = 0;
    longint      s_sec = 0;
    logic [15:0] m_rd = 16'd0;
    logic [15:0] stg [3] = '{16'd0, 16'd0, 16'd0};

    function automatic logic [15:0] word_of(int t, int u, longint s, int sel);
        case (sel)
            0: return 16'(u % 65536);
            1: return 16'((t % 16) * 16 + (u / 65536) % 16);
            2: return 16'(s % 65536);
            default: return 16'((s / 65536) % 65536);
        endcase
    endfunction

    always @(posedge clk) begin
        seen_edge = 1'b1;
        if (rst) begin
            m_tenth = 0; m_usec = 0; m_sec = 0; m_presc = 0; m_armed = 1'b0;
            s_tenth = 0; s_usec = 0; s_sec = 0; m_rd = 16'd0;
            stg[0] = 16'd0; stg[1] = 16'd0; stg[2] = 16'd0;
        end else begin
            if (rd_en) begin
                if (word_sel == 2'd0) begin
                    s_tenth = m_tenth; s_usec = m_usec; s_sec = m_sec;
                    m_rd = word_of(m_tenth, m_usec, m_sec, 0);
                end else begin
                    m_rd = word_of(s_tenth, s_usec, s_sec, int'(word_sel));
                end
            end
            if (wr_en && word_sel != 2'd3) begin
                stg[word_sel] = wr_data;
            end else if (wr_en) begin
                m_tenth = int'(stg[1][7:4]);
                if (m_tenth > 9) m_tenth = 9;
                m_usec = int'(stg[1][3:0]) * 65536 + int'(stg[0]);
                if (m_usec > 999999) m_usec = 999999;
                m_sec = longint'(wr_data) * 65536 + longint'(stg[2]);
                m_armed = 1'b1;
                m_presc = 0;
            end else if (m_armed) begin
                if (m_presc == DIV - 1) begin
                    m_presc = 0;
                    m_tenth++;
                    if (m_tenth == 10) begin
                        m_tenth = 0;
                        m_usec++;
                        if (m_usec == 1000000) begin
                            m_usec = 0;
                            m_sec = (m_sec + 1) % 64'h1_0000_0000;
                        end
                    end
                end else begin
                    m_presc++;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            checks++;
            if (rd_data !== m_rd) begin
                errors++;
                $display("FAIL R9 model rd_data act %h exp %h at %0t", rd_data, m_rd, $time);
            end
            checks++;
            if (armed !== m_armed) begin
                errors++;
                $display("FAIL R4 model armed act %b exp %b at %0t", armed, m_armed, $time);
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act %h exp %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        wr_en = 1'b1; word_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, input logic [15:0] exp, input string req);
        rd_en = 1'b1; word_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic load4(input logic [15:0] w0, input logic [15:0] w1,
                         input logic [15:0] w2, input logic [15:0] w3);
        wr(2'd0, w0); wr(2'd1, w1); wr(2'd2, w2); wr(2'd3, w3);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk("R1 armed after reset", {15'd0, armed}, 16'd0);
        chk("R1 rd_data after reset", rd_data, 16'd0);

        repeat (50) @(negedge clk);
        rd(2'd0, 16'h0000, "R2 idle word0");
        rd(2'd1, 16'h0000, "R2 idle word1");
        chk("R2 still disarmed", {15'd0, armed}, 16'd0);

        wr(2'd0, 16'h1234); wr(2'd1, 16'h0056); wr(2'd2, 16'hBEEF);
        rd(2'd0, 16'h0000, "R3 staged word0 no effect");
        rd(2'd2, 16'h0000, "R3 staged word2 no effect");
        chk("R3 staging does not arm", {15'd0, armed}, 16'd0);

        wr(2'd3, 16'hCAFE);
        chk("R4 armed after load", {15'd0, armed}, 16'd1);
        rd(2'd0, 16'h1234, "R8 word0 usec low");
        rd(2'd1, 16'h0056, "R8 word1 tenth and usec high");
        rd(2'd2, 16'hBEEF, "R8 word2 sec low");
        rd(2'd3, 16'hCAFE, "R8 word3 sec high");

        // full wrap of all fields
        load4(16'h423F, 16'h009F, 16'hFFFF, 16'hFFFF);
        rd(2'd0, 16'h423F, "R4 no advance right after load");
        rd(2'd1, 16'h009F, "R4 tenth held after load");
        repeat (DIV - 3) @(negedge clk);
        rd(2'd0, 16'h423F, "R5 no advance before tick edge");
        rd(2'd0, 16'h0000, "R6 usec wrap low word");
        rd(2'd1, 16'h0000, "R5 tenth wrap to zero");
        rd(2'd2, 16'h0000, "R7 sec low wrap");
        rd(2'd3, 16'h0000, "R7 sec high wrap");

        // carry across the 16-bit word boundary
        load4(16'hFFFF, 16'h0090, 16'h0002, 16'h0000);
        repeat (DIV) @(negedge clk);
        rd(2'd0, 16'h0000, "R6 carry into usec high bits low word");
        rd(2'd1, 16'h0001, "R6 carry into usec high bits");
        rd(2'd2, 16'h0002, "R6 seconds unchanged");

        // snapshot coherence
        load4(16'h0005, 16'h0020, 16'h0007, 16'h0000);
        rd(2'd0, 16'h0005, "R9 snapshot capture");
        repeat (3 * DIV) @(negedge clk);
        rd(2'd1, 16'h0020, "R9 word1 from snapshot");
        rd(2'd0, 16'h0005, "R9 live word0");
        rd(2'd1, 16'h0050, "R5 three ticks counted");

        // clamping of out-of-range loads
        load4(16'hFFFF, 16'h00FF, 16'h0000, 16'h0000);
        rd(2'd0, 16'h423F, "R10 usec clamp");
        rd(2'd1, 16'h009F, "R10 tenth and usec clamp");

        // load on a tick edge
        load4(16'h0100, 16'h0030, 16'h0011, 16'h0000);
        repeat (DIV - 1) @(negedge clk);
        wr(2'd3, 16'h0000);
        rd(2'd0, 16'h0100, "R11 load wins word0");
        rd(2'd1, 16'h0030, "R11 load wins tenth");

        // free run with mixed reads, compared against the model each cycle
        for (int i = 0; i < 600; i++) begin
            rd_en = (i % 3) != 0;
            word_sel = 2'(i % 4);
            @(negedge clk);
        end
        rd_en = 1'b0;
        wr(2'd0, 16'hAAAA);
        repeat (DIV * 2) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule